// File: doc/BRIEF.md
# Fetch Queue with Resteer Trim

This block is the instruction queue between fetch and decode. Each cycle the front end may offer one fetch block of up to 16 instruction slots. Every slot carries an instruction word and its PC, and the whole block carries a tag. A per-slot skip mask marks the short runs that a short forward taken branch jumps over. Those slots are squeezed out while the block is written, so the queue holds only the executed path in order. Decode takes up to 8 of the oldest entries per cycle.

When a slower predictor overrides the early one, the front end raises a resteer naming the block tag and the slot of the overridden branch. That block's entries up to and including that slot stay, together with everything older, and all younger entries are dropped. Fetch then restarts elsewhere, and during the empty cycles that follow, decode keeps draining what remains. A separate clear input empties the whole queue after a true misprediction. A block tag must be unique among the blocks held in the queue.

Top module: `insn_fetch_queue`

## Requirements
- R1: An accepted block stores, in rising slot order and with nothing between them, every slot s with s < wr_len whose skip bit wr_skip[s] is 0; bit s of wr_skip set means slot s is removed.
- R2: Slots at or above wr_len are never stored, whatever their skip bits or data.
- R3: dec_cnt equals the smaller of the occupancy and 8 in any cycle with neither resteer nor clear. Lane 0 of dec_insn/dec_pc is the oldest entry. When dec_ready is high, those dec_cnt entries leave at the clock edge.
- R4: stall is high when wr_valid is high and the free space (depth minus occupancy at the start of the cycle) is smaller than wr_len. A stalled block is not written, and free space equal to wr_len is accepted.
- R5: On a resteer, entries older than the named block stay, as do the block's entries whose original slot is at most rs_slot. Every younger entry is removed at that edge. This holds whether or not part of the block has already drained.
- R6: A resteer naming a tag that no entry carries leaves the queue unchanged.
- R7: In a resteer or clear cycle, dec_cnt is 0, nothing drains, and a concurrent write is dropped.
- R8: A clear empties the queue at the next edge.
- R9: After reset the queue is empty, dec_cnt is 0 and stall is 0.
- R10: Entries drain in exact written order across pointer wrap, under continuous writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear the whole queue |
| wr_valid | input | 1 | Fetch block offered |
| wr_len | input | 5 | Number of slots in the block (1..16) |
| wr_skip | input | 16 | Per-slot skip mask |
| wr_tag | input | 4 | Block tag |
| wr_insn | input | 512 | Slot instructions, slot s at bits s*32 |
| wr_pc | input | 512 | Slot PCs, slot s at bits s*32 |
| stall | output | 1 | Block refused for lack of space |
| rs_valid | input | 1 | Resteer request |
| rs_tag | input | 4 | Tag of the block holding the overridden branch |
| rs_slot | input | 4 | Original slot of the overridden branch |
| dec_ready | input | 1 | Decode takes the offered lanes |
| dec_cnt | output | 4 | Number of valid decode lanes |
| dec_insn | output | 256 | Decode lane instructions, lane l at bits l*32 |
| dec_pc | output | 256 | Decode lane PCs |

## Verification
stall and dec_cnt are combinational from the stored state and the current inputs, so the bench samples them in the same cycle, a few ns after its negedge drive. Writes, resteer trims, clears and pops take effect at the next rising edge. The scoreboard applies them to its model just after that edge, and pops compare lanes at the negedge before the edge that removes them. Targeted peeks of dec_cnt with dec_ready low then confirm the occupancy that each write, trim, ignored resteer and clear must leave.

// File: rtl/insn_fetch_queue.sv
module insn_fetch_queue #(
  parameter int IW = 32,
  parameter int PCW = 32,
  parameter int TAGW = 4,
  parameter int FW = 16,
  parameter int DW = 8,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int LW = $clog2(FW + 1),
  localparam int SW = $clog2(FW),
  localparam int OW = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_valid,
  input  logic [LW-1:0]    wr_len,
  input  logic [FW-1:0]    wr_skip,
  input  logic [TAGW-1:0]  wr_tag,
  input  logic [FW*IW-1:0] wr_insn,
  input  logic [FW*PCW-1:0] wr_pc,
  output logic             stall,
  input  logic             rs_valid,
  input  logic [TAGW-1:0]  rs_tag,
  input  logic [SW-1:0]    rs_slot,
  input  logic             dec_ready,
  output logic [OW-1:0]    dec_cnt,
  output logic [DW*IW-1:0] dec_insn,
  output logic [DW*PCW-1:0] dec_pc
);

  logic [IW-1:0]   m_insn [DEPTH];
  logic [PCW-1:0]  m_pc   [DEPTH];
  logic [TAGW-1:0] m_tag  [DEPTH];
  logic [SW-1:0]   m_slot [DEPTH];

  logic [AW-1:0] head, tail;
  logic [CW-1:0] occ, free, cut;
  logic [LW-1:0] wpos [FW];
  logic [LW-1:0] nkeep;
  logic [FW-1:0] keep;
  logic [OW-1:0] avail, pop;
  logic busy, accept;

  assign free   = CW'(DEPTH) - occ;
  assign stall  = wr_valid && (int'(free) < int'(wr_len));
  assign busy   = rs_valid || flush;
  assign accept = wr_valid && !stall && !busy;
  assign avail  = (occ > CW'(DW)) ? OW'(DW) : OW'(occ);
  assign dec_cnt = busy ? '0 : avail;
  assign pop    = dec_ready ? dec_cnt : '0;

  always_comb begin
    logic [LW-1:0] acc;
    acc = '0;
    for (int s = 0; s < FW; s++) begin
      keep[s] = (LW'(s) < wr_len) && !wr_skip[s];
      wpos[s] = acc;
      if (keep[s]) acc = acc + 1'b1;
    end
    nkeep = acc;
  end

  always_comb begin
    logic seen, found, m;
    logic [AW-1:0] idx;
    cut = occ;
    seen = 1'b0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + AW'(i);
      m = (m_tag[idx] == rs_tag);
      if (CW'(i) < occ) begin
        seen = seen | m;
        if (!found && seen && !(m && m_slot[idx] <= rs_slot)) begin
          found = 1'b1;
          cut = CW'(i);
        end
      end
    end
  end

  generate
    for (genvar l = 0; l < DW; l++) begin : g_lane
      logic [AW-1:0] ridx;
      assign ridx = head + AW'(l);
      assign dec_insn[l*IW +: IW]  = m_insn[ridx];
      assign dec_pc[l*PCW +: PCW]  = m_pc[ridx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (rs_valid) begin
      tail <= head + cut[AW-1:0];
      occ  <= cut;
    end else begin
      head <= head + AW'(pop);
      if (accept) tail <= tail + AW'(nkeep);
      occ  <= occ + (accept ? CW'(nkeep) : CW'(0)) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < FW; s++) begin
      if (accept && keep[s]) begin
        m_insn[tail + AW'(wpos[s])] <= wr_insn[s*IW +: IW];
        m_pc[tail + AW'(wpos[s])]   <= wr_pc[s*PCW +: PCW];
        m_tag[tail + AW'(wpos[s])]  <= wr_tag;
        m_slot[tail + AW'(wpos[s])] <= SW'(s);
      end
    end
  end

endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int DW = 8,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int OW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          rs_valid,
  input logic          stall,
  input logic          dec_ready,
  input logic [OW-1:0] dec_cnt,
  input logic [CW-1:0] occ
);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  assert_drain_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dec_cnt) <= DW) && (int'(dec_cnt) <= int'(occ)));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

  assert_trim_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !flush) |=> occ <= $past(occ));

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !dec_ready && !rs_valid && !flush) |=> occ == $past(occ));

endmodule

bind insn_fetch_queue fq_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rs_valid(rs_valid),
  .stall(stall), .dec_ready(dec_ready), .dec_cnt(dec_cnt), .occ(occ)
);

// File: tb/sim_insn_fetch_queue.sv
`timescale 1ns/1ps
module sim_insn_fetch_queue;
  localparam int IW = 32, PCW = 32, TAGW = 4, FW = 16, DW = 8, DEPTH = 32;

  logic clk = 0, rst_n = 0, flush = 0, wr_valid = 0, rs_valid = 0, dec_ready = 0;
  logic [4:0] wr_len = 0;
  logic [FW-1:0] wr_skip = 0;
  logic [TAGW-1:0] wr_tag = 0, rs_tag = 0;
  logic [3:0] rs_slot = 0;
  logic [FW*IW-1:0] wr_insn = 0;
  logic [FW*PCW-1:0] wr_pc = 0;
  logic stall;
  logic [3:0] dec_cnt;
  logic [DW*IW-1:0] dec_insn;
  logic [DW*PCW-1:0] dec_pc;

  insn_fetch_queue u0 (.*);

  always #10 clk = ~clk;

  typedef struct {logic [31:0] insn; logic [31:0] pc; logic [3:0] tag; logic [3:0] slot;} ent_t;
  ent_t sbq[$];
  int checks = 0, errors = 0, seq = 0;
  bit running = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && running) begin
      int exp;
      exp = (rs_valid || flush) ? 0 : (sbq.size() > DW ? DW : sbq.size());
      chk(dec_cnt == exp, "R3 dec_cnt", dec_cnt, exp);
      if (dec_ready) begin
        for (int l = 0; l < dec_cnt && sbq.size() > 0; l++) begin
          ent_t e;
          e = sbq.pop_front();
          chk(dec_insn[l*IW +: IW] == e.insn, "R1/R10 insn order", dec_insn[l*IW +: IW], e.insn);
          chk(dec_pc[l*PCW +: PCW] == e.pc, "R1/R10 pc order", dec_pc[l*PCW +: PCW], e.pc);
        end
      end
    end
  end

  task automatic step(bit wv, logic [3:0] tag, int len, logic [15:0] skip, logic [31:0] base,
                      bit rv, logic [3:0] rtag, logic [3:0] rslot, bit fl, output bit stalled);
    bit exp_st;
    @(negedge clk);
    wr_valid = wv; wr_tag = tag; wr_len = 5'(len); wr_skip = skip;
    for (int s = 0; s < FW; s++) begin
      wr_insn[s*IW +: IW] = {tag, 8'(seq), 16'h0, 4'(s)};
      wr_pc[s*PCW +: PCW] = base + 32'(4*s);
    end
    rs_valid = rv; rs_tag = rtag; rs_slot = rslot; flush = fl;
    #1;
    exp_st = wv && ((DEPTH - sbq.size()) < len);
    chk(stall == exp_st, "R4 stall", stall, exp_st);
    stalled = exp_st;
    @(posedge clk);
    if (fl) sbq.delete();
    else if (rv) begin
      int cut;
      bit seen;
      cut = sbq.size(); seen = 0;
      for (int i = 0; i < sbq.size(); i++) begin
        bit m;
        m = (sbq[i].tag == rtag);
        seen |= m;
        if (seen && !(m && sbq[i].slot <= rslot)) begin cut = i; break; end
      end
      while (sbq.size() > cut) void'(sbq.pop_back());
    end else if (wv && !exp_st) begin
      for (int s = 0; s < len; s++)
        if (!skip[s]) sbq.push_back('{{tag, 8'(seq), 16'h0, 4'(s)}, base + 32'(4*s), tag, 4'(s)});
    end
    if (wv) seq++;
    #1;
    wr_valid = 0; rs_valid = 0; flush = 0;
  endtask

  task automatic wr(logic [3:0] tag, int len, logic [15:0] skip, output bit st);
    step(1, tag, len, skip, 32'h1000 * (seq + 1), 0, 0, 0, 0, st);
  endtask

  task automatic peek(int exp, string req);
    @(negedge clk); #3;
    chk(dec_cnt == exp, req, dec_cnt, exp);
  endtask

  task automatic drain_all();
    @(negedge clk);
    dec_ready = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #3;
      if (sbq.size() == 0) break;
    end
    @(posedge clk); #1;
    dec_ready = 0;
    peek(0, "R3 drained empty");
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit st;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #3;
    chk(dec_cnt == 0, "R9 reset dec_cnt", dec_cnt, 0);
    chk(stall == 0, "R9 reset stall", stall, 0);
    running = 1;

    wr(4'h1, 5, 16'hFFE0, st);
    peek(5, "R2 only slots below wr_len stored");
    drain_all();

    wr(4'h2, 16, 16'h0060, st);
    peek(8, "R1 compacted block, drain capped");
    drain_all();

    wr(4'h3, 16, 16'h0000, st);
    wr(4'h4, 16, 16'h0000, st);
    chk(st == 0, "R4 exact fit accepted", st, 0);
    wr(4'h5, 1, 16'h0000, st);
    chk(st == 1, "R4 full queue stalls", st, 1);
    drain_all();

    wr(4'h6, 16, 16'h0018, st);
    wr(4'h7, 16, 16'h0000, st);
    step(1, 4'h8, 2, 16'h0, 32'h9000, 1, 4'h6, 4'd7, 0, st);
    peek(6, "R5/R7 trim keeps slots to branch, write dropped");
    drain_all();

    wr(4'h9, 16, 16'h0000, st);
    @(negedge clk); dec_ready = 1;
    @(negedge clk); dec_ready = 0;
    wr(4'hA, 8, 16'h0000, st);
    step(0, 0, 0, 0, 0, 1, 4'h9, 4'd10, 0, st);
    peek(3, "R5 trim on partly drained block");
    step(0, 0, 0, 0, 0, 1, 4'hF, 4'd0, 0, st);
    peek(3, "R6 absent tag no change");
    drain_all();

    wr(4'hB, 16, 16'h0000, st);
    step(1, 4'hC, 4, 16'h0, 32'h7000, 0, 0, 0, 1, st);
    peek(0, "R8/R7 clear empties");

    @(negedge clk); dec_ready = 1;
    for (int k = 0; k < 30; k++) begin
      int len;
      logic [15:0] sk;
      len = (k % 16) + 1;
      sk = (k % 3 == 0) ? 16'h0006 : ((k % 3 == 1) ? 16'h0780 : 16'h0);
      do wr(4'(k), len, sk, st); while (st);
    end
    drain_all();

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule